// File: doc/BRIEF.md
# Descriptor Fetch Bus Sequencer

This block is the bus-master sequencer that reads one ring descriptor over a multiplexed 32-bit address/data bus. A fetch request carries the descriptor base address, a 2-bit layout code and a burst-enable flag. The block turns these into the required read transactions. Each transaction has an address phase, one turnaround cycle and a data phase, and separate transactions are divided by an idle cycle. The block then collects the two returned words into three descriptor words and pulses done.

The layout code sets everything else: where each read goes, whether the two words arrive in one burst, and which bits of each word reach which descriptor field. Bus arbitration, retries, descriptor writes and ring-pointer handling belong to neighbouring logic.

Top module: `desc_fetch_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, bus_frame, bus_addr_phase, bus_data_phase, bus_rd_cmd are 0 and bus_byte_en is 4'b0000.
- R2: Every cycle with bus_addr_phase=1 is followed by exactly one turnaround cycle (bus_frame=1, no address phase, no data phase) and then a cycle with bus_data_phase=1.
- R3: During every transaction (bus_frame=1), bus_byte_en is 4'b1111 and bus_rd_cmd is 1, so every transfer is a full-width read.
- R4: Layout 0 (16-bit legacy) reads base+0x0 and then base+0x4 as two single transactions separated by one idle cycle (bus_frame=0). With first word A and second word B: desc_w0={8'h00,A[23:0]}, desc_w1={A[31:24],8'h00,B[15:0]}, desc_w2={16'h0000,B[31:16]}.
- R5: Layouts 1 and 2 read base+0x4 and then base+0x0 as two single transactions separated by one idle cycle. desc_w1 is the first word, desc_w0 is the second word, and desc_w2 is 0.
- R6: Layout 3 with burst-enable 0 reads base+0x4 and then base+0x8 as two single transactions separated by one idle cycle. desc_w1 is the first word, desc_w0 is the second word, and desc_w2 is 0.
- R7: Layout 3 with burst-enable 1 uses a single address phase at base+0x4, a turnaround cycle, and two data beats with bus_data_phase held high between them. The second beat returns the word at base+0x8. For layouts 0 to 2 the burst-enable input has no effect.
- R8: A data word is captured only in a data-phase cycle with bus_tgt_ready=1. A data-phase cycle with bus_tgt_ready=0 is a wait state: the data phase continues in the next cycle and the sequence does not change.
- R9: done is high for exactly one cycle, the cycle right after the second word is captured. The descriptor outputs are valid in that cycle and stay unchanged until the next request is accepted.
- R10: A request is accepted only while busy=0. busy stays high from the accepting edge until the cycle after done. Requests made while busy=1 are ignored. The layout, burst flag and base are sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request strobe |
| req_base | input | 32 | Descriptor base address |
| req_layout | input | 2 | Descriptor layout code (0 to 3) |
| req_burst_en | input | 1 | Burst permission for layout 3 |
| busy | output | 1 | Fetch in progress |
| bus_frame | output | 1 | Transaction active (address, turnaround, data) |
| bus_addr_phase | output | 1 | Address phase, address on bus_ad_out |
| bus_data_phase | output | 1 | Initiator ready for a data beat |
| bus_rd_cmd | output | 1 | Read command for the current transaction |
| bus_byte_en | output | 4 | Byte enables, active high |
| bus_ad_out | output | 32 | Address driven in the address phase, 0 otherwise |
| bus_ad_in | input | 32 | Read data from the target |
| bus_tgt_ready | input | 1 | Target has valid data this cycle |
| done | output | 1 | One-cycle fetch completion pulse |
| desc_w0 | output | 32 | Descriptor word 0 |
| desc_w1 | output | 32 | Descriptor word 1 |
| desc_w2 | output | 32 | Descriptor word 2 (legacy layout only) |

## Verification
The hardest case to reach from the ports is a burst whose two beats are split by target wait states. The data phase must then stay asserted across stalled cycles, and the second word must still come from base+0x8. The bench's memory model lowers target-ready at random, with a high stall rate in part of the runs. Burst requests are given with every layout code. A monitor counts how often the data phase falls before the second capture: this count is zero for a burst and one for single transfers. Requests repeated during busy test that the latched layout is kept.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;
    localparam int ADDR_W    = 32;
    localparam int WORD_W    = 32;
    localparam int BE_W      = WORD_W / 8;
    localparam int NUM_WORDS = 2;
    localparam int IDX_W     = $clog2(NUM_WORDS);

    typedef enum logic [1:0] {
        LAYOUT_LEGACY16 = 2'd0,
        LAYOUT_WIDE_A   = 2'd1,
        LAYOUT_WIDE_B   = 2'd2,
        LAYOUT_BURSTABLE = 2'd3
    } layout_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_TURN,
        PH_DATA,
        PH_GAP,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] first_off;
        logic [ADDR_W-1:0] second_off;
        logic              burst;
    } plan_t;

    typedef struct packed {
        logic [WORD_W-1:0] dw2;
        logic [WORD_W-1:0] dw1;
        logic [WORD_W-1:0] dw0;
    } desc_t;

    function automatic plan_t make_plan(layout_e lay, logic burst_req);
        plan_t p;
        case (lay)
            LAYOUT_LEGACY16: begin
                p.first_off  = ADDR_W'(4'h0);
                p.second_off = ADDR_W'(4'h4);
                p.burst      = 1'b0;
            end
            LAYOUT_BURSTABLE: begin
                p.first_off  = ADDR_W'(4'h4);
                p.second_off = ADDR_W'(4'h8);
                p.burst      = burst_req;
            end
            default: begin
                p.first_off  = ADDR_W'(4'h4);
                p.second_off = ADDR_W'(4'h0);
                p.burst      = 1'b0;
            end
        endcase
        return p;
    endfunction

    function automatic desc_t unpack_words(layout_e lay,
                                           logic [WORD_W-1:0] w_first,
                                           logic [WORD_W-1:0] w_second);
        desc_t d;
        if (lay == LAYOUT_LEGACY16) begin
            d.dw0 = {8'h00, w_first[23:0]};
            d.dw1 = {w_first[31:24], 8'h00, w_second[15:0]};
            d.dw2 = {16'h0000, w_second[31:16]};
        end else begin
            d.dw0 = w_second;
            d.dw1 = w_first;
            d.dw2 = '0;
        end
        return d;
    endfunction
endpackage

// File: rtl/dfetch_req_latch.sv
module dfetch_req_latch
    import dfetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [1:0]        layout_in,
    input  logic              burst_in,
    output logic [ADDR_W-1:0] base_q,
    output layout_e           layout_q,
    output plan_t             plan_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            layout_q <= LAYOUT_LEGACY16;
            plan_q   <= '0;
        end else if (accept) begin
            base_q   <= base_in;
            layout_q <= layout_e'(layout_in);
            plan_q   <= make_plan(layout_e'(layout_in), burst_in);
        end
    end
endmodule

// File: rtl/dfetch_phase_fsm.sv
module dfetch_phase_fsm
    import dfetch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             burst,
    input  logic             tgt_ready,
    output phase_e           phase,
    output logic [IDX_W-1:0] beat,
    output logic             cap_en
);
    localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(NUM_WORDS - 1);

    phase_e           phase_n;
    logic [IDX_W-1:0] beat_n;

    always_comb begin
        phase_n = phase;
        beat_n  = beat;
        case (phase)
            PH_IDLE: if (start) begin
                phase_n = PH_ADDR;
                beat_n  = '0;
            end
            PH_ADDR: phase_n = PH_TURN;
            PH_TURN: phase_n = PH_DATA;
            PH_DATA: if (tgt_ready) begin
                if (beat == LAST_BEAT) begin
                    phase_n = PH_DONE;
                end else begin
                    beat_n  = beat + 1'b1;
                    phase_n = burst ? PH_DATA : PH_GAP;
                end
            end
            PH_GAP:  phase_n = PH_ADDR;
            PH_DONE: phase_n = PH_IDLE;
            default: phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            beat  <= '0;
        end else begin
            phase <= phase_n;
            beat  <= beat_n;
        end
    end

    assign cap_en = (phase == PH_DATA) && tgt_ready;
endmodule

// File: rtl/dfetch_word_store.sv
module dfetch_word_store
    import dfetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [WORD_W-1:0] data_in,
    input  layout_e           layout,
    output desc_t             desc
);
    logic [WORD_W-1:0] words [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[i] <= '0;
            end else if (cap_en && (cap_idx == IDX_W'(i))) begin
                words[i] <= data_in;
            end
        end
    end

    assign desc = unpack_words(layout, words[0], words[1]);
endmodule

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq
    import dfetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [1:0]        req_layout,
    input  logic              req_burst_en,
    output logic              busy,
    output logic              bus_frame,
    output logic              bus_addr_phase,
    output logic              bus_data_phase,
    output logic              bus_rd_cmd,
    output logic [BE_W-1:0]   bus_byte_en,
    output logic [ADDR_W-1:0] bus_ad_out,
    input  logic [WORD_W-1:0] bus_ad_in,
    input  logic              bus_tgt_ready,
    output logic              done,
    output logic [WORD_W-1:0] desc_w0,
    output logic [WORD_W-1:0] desc_w1,
    output logic [WORD_W-1:0] desc_w2
);
    phase_e            phase;
    logic [IDX_W-1:0]  beat;
    logic              cap_en;
    logic              accept;
    logic [ADDR_W-1:0] base_q;
    layout_e           layout_q;
    plan_t             plan_q;
    desc_t             desc;

    assign accept = req_valid && (phase == PH_IDLE);

    dfetch_req_latch u_req (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .base_in   (req_base),
        .layout_in (req_layout),
        .burst_in  (req_burst_en),
        .base_q    (base_q),
        .layout_q  (layout_q),
        .plan_q    (plan_q)
    );

    dfetch_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .burst     (plan_q.burst),
        .tgt_ready (bus_tgt_ready),
        .phase     (phase),
        .beat      (beat),
        .cap_en    (cap_en)
    );

    dfetch_word_store u_store (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_idx (beat),
        .data_in (bus_ad_in),
        .layout  (layout_q),
        .desc    (desc)
    );

    assign busy           = (phase != PH_IDLE);
    assign bus_addr_phase = (phase == PH_ADDR);
    assign bus_data_phase = (phase == PH_DATA);
    assign bus_frame      = (phase == PH_ADDR) || (phase == PH_TURN) || (phase == PH_DATA);
    assign bus_rd_cmd     = bus_frame;
    assign bus_byte_en    = bus_frame ? {BE_W{1'b1}} : {BE_W{1'b0}};
    assign bus_ad_out     = bus_addr_phase
                          ? base_q + ((beat == '0) ? plan_q.first_off : plan_q.second_off)
                          : '0;
    assign done           = (phase == PH_DONE);
    assign desc_w0        = desc.dw0;
    assign desc_w1        = desc.dw1;
    assign desc_w2        = desc.dw2;
endmodule

// File: rtl/dfetch_chk.sv
module dfetch_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       bus_frame,
    input logic       bus_addr_phase,
    input logic       bus_data_phase,
    input logic       bus_rd_cmd,
    input logic [3:0] bus_byte_en,
    input logic       bus_tgt_ready,
    input logic       done
);
    // R2
    addr_turn_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr_phase |=> (bus_frame && !bus_addr_phase && !bus_data_phase));

    // R2
    turn_data_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr_phase |=> ##1 bus_data_phase);

    // R3
    full_read_chk: assert property (@(posedge clk) disable iff (rst)
        bus_frame |-> (bus_byte_en == 4'hF && bus_rd_cmd && busy));

    // R6
    idle_before_addr_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr_phase |-> !$past(bus_frame));

    // R8
    wait_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_data_phase && !bus_tgt_ready) |=> bus_data_phase);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_after_cap_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_data_phase && bus_tgt_ready));
endmodule

bind desc_fetch_seq dfetch_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .busy           (busy),
    .bus_frame      (bus_frame),
    .bus_addr_phase (bus_addr_phase),
    .bus_data_phase (bus_data_phase),
    .bus_rd_cmd     (bus_rd_cmd),
    .bus_byte_en    (bus_byte_en),
    .bus_tgt_ready  (bus_tgt_ready),
    .done           (done)
);

// File: tb/desc_fetch_seq_test.sv
module desc_fetch_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_base = '0;
    logic [1:0]  req_layout = '0;
    logic        req_burst_en = 1'b0;
    logic        busy, bus_frame, bus_addr_phase, bus_data_phase, bus_rd_cmd, done;
    logic [3:0]  bus_byte_en;
    logic [31:0] bus_ad_out;
    logic [31:0] bus_ad_in = '0;
    logic        bus_tgt_ready = 1'b0;
    logic [31:0] desc_w0, desc_w1, desc_w2;

    int checks = 0;
    int failures = 0;

    int          cyc = 0;
    int          ready_pct = 100;
    logic [31:0] addr_log [4];
    int          n_addr = 0, n_caps = 0, cap_cyc = 0;
    int          gap_bad = 0, turn_bad = 0, be_bad = 0, dp_drops = 0, done_late = 0;
    logic        prev_addr = 0, prev_turn = 0, prev_frame = 0, prev_busy = 0, prev_data = 0;
    logic [31:0] cur_addr = '0;

    desc_fetch_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_base(req_base),
        .req_layout(req_layout), .req_burst_en(req_burst_en), .busy(busy),
        .bus_frame(bus_frame), .bus_addr_phase(bus_addr_phase),
        .bus_data_phase(bus_data_phase), .bus_rd_cmd(bus_rd_cmd),
        .bus_byte_en(bus_byte_en), .bus_ad_out(bus_ad_out), .bus_ad_in(bus_ad_in),
        .bus_tgt_ready(bus_tgt_ready), .done(done), .desc_w0(desc_w0),
        .desc_w1(desc_w1), .desc_w2(desc_w2)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] memf(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory-model responder and bus monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (busy && !prev_busy) begin
                n_addr = 0; n_caps = 0; gap_bad = 0; turn_bad = 0;
                be_bad = 0; dp_drops = 0; done_late = 0;
            end
            if (bus_frame && (bus_byte_en != 4'hF || !bus_rd_cmd)) be_bad++;
            if (prev_addr && (bus_addr_phase || bus_data_phase || !bus_frame)) turn_bad++;
            if (prev_turn && !bus_data_phase) turn_bad++;
            if (prev_data && !bus_data_phase && n_caps < 2) dp_drops++;
            if (done && cyc != cap_cyc + 1) done_late++;
            if (bus_addr_phase) begin
                if (n_addr < 4) addr_log[n_addr] = bus_ad_out;
                n_addr++;
                if (prev_frame) gap_bad++;
                cur_addr = bus_ad_out;
            end
            if (bus_data_phase) begin
                bus_tgt_ready = ($urandom % 100) < ready_pct;
                bus_ad_in = bus_tgt_ready ? memf(cur_addr) : $urandom;
                if (bus_tgt_ready) begin
                    n_caps++;
                    cap_cyc = cyc;
                    cur_addr = cur_addr + 32'd4;
                end
            end else begin
                bus_tgt_ready = 1'b0;
                bus_ad_in = $urandom;
            end
            prev_turn  = prev_addr;
            prev_addr  = bus_addr_phase;
            prev_frame = bus_frame;
            prev_busy  = busy;
            prev_data  = bus_data_phase;
        end
    end

    task automatic run_fetch(logic [31:0] base, logic [1:0] lay, logic burst,
                             int pct, bit poke_busy);
        logic [31:0] a0, a1, w0, w1, e0, e1, e2;
        logic [31:0] h0, h1, h2;
        bit use_burst;
        int  wait_n;
        use_burst = (lay == 2'd3) && burst;
        a0 = (lay == 2'd0) ? base : base + 32'd4;
        a1 = (lay == 2'd0) ? base + 32'd4 : (lay == 2'd3) ? base + 32'd8 : base;
        w0 = memf(a0);
        w1 = memf(a1);
        if (lay == 2'd0) begin
            e0 = {8'h00, w0[23:0]};
            e1 = {w0[31:24], 8'h00, w1[15:0]};
            e2 = {16'h0000, w1[31:16]};
        end else begin
            e0 = w1; e1 = w0; e2 = 32'h0;
        end
        ready_pct = pct;
        @(negedge clk);
        req_valid = 1'b1; req_base = base; req_layout = lay; req_burst_en = burst;
        @(negedge clk);
        check("R10 busy after accept", {31'd0, busy}, 32'd1);
        if (poke_busy) begin
            req_base = ~base; req_layout = lay ^ 2'd3; req_burst_en = ~burst;
            repeat (2) @(negedge clk);
        end
        req_valid = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 400) begin
            @(negedge clk);
            wait_n++;
        end
        check("R9 done reached", {31'd0, done}, 32'd1);
        // R4 R5 R6 R7: field mapping; R8: data from ready beats only
        check("R4/R5/R6 R8 desc_w0", desc_w0, e0);
        check("R4/R5/R6 R8 desc_w1", desc_w1, e1);
        check("R4 desc_w2", desc_w2, e2);
        @(negedge clk);
        check("R9 done one cycle", {31'd0, done}, 32'd0);
        check("R9 done after last capture", done_late, 0);
        check("R10 idle after done", {31'd0, busy}, 32'd0);
        check("R2 turnaround", turn_bad, 0);
        check("R3 byte enables", be_bad, 0);
        check("R7 address phases", n_addr, use_burst ? 1 : 2);
        check("R4/R5/R6 first address", addr_log[0], a0);
        if (!use_burst) begin
            check("R4/R5/R6 second address", addr_log[1], a1);
            check("R6 idle gap", gap_bad, 0);
        end
        check("R7 data phase drops", dp_drops, use_burst ? 0 : 1);
        h0 = desc_w0; h1 = desc_w1; h2 = desc_w2;
        repeat (3) @(negedge clk);
        check("R9 fields held", desc_w0 ^ desc_w1 ^ desc_w2, h0 ^ h1 ^ h2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", {26'd0, busy, done, bus_frame, bus_addr_phase,
              bus_data_phase, bus_rd_cmd}, 32'd0);
        check("R1 reset byte enables", {28'd0, bus_byte_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {26'd0, busy, done, bus_frame, bus_addr_phase,
              bus_data_phase, bus_rd_cmd}, 32'd0);
        // directed corner cases
        run_fetch(32'h1000_0100, 2'd0, 1'b0, 100, 0);
        run_fetch(32'h1000_0200, 2'd0, 1'b1, 100, 0);   // R7 burst ignored
        run_fetch(32'h2000_0010, 2'd1, 1'b1, 100, 0);
        run_fetch(32'h2000_0020, 2'd2, 1'b0, 100, 0);
        run_fetch(32'h3000_0040, 2'd3, 1'b0, 100, 0);
        run_fetch(32'h3000_0080, 2'd3, 1'b1, 100, 0);
        run_fetch(32'h3000_00C0, 2'd3, 1'b1, 20, 0);    // R8 stalled burst
        run_fetch(32'hFFFF_FFF0, 2'd3, 1'b0, 40, 1);    // R10 poke while busy
        run_fetch(32'h4000_0000, 2'd0, 1'b0, 30, 1);
        // constrained random
        for (int i = 0; i < 48; i++) begin
            int pct_sel;
            pct_sel = $urandom % 3;
            run_fetch({$urandom_range(32'h0FFF_FFFF, 0), 4'h0}, 2'($urandom % 4),
                      1'($urandom % 2), (pct_sel == 0) ? 100 : (pct_sel == 1) ? 60 : 25,
                      bit'($urandom % 2));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule